// File: doc/BRIEF.md
# Transmit Cell Octet-Five Processor

This block sits on the transmit side of a cell-based link. It divides time into slots of 53 octets and emits one octet per clock. When a slot begins and the transmit FIFO reports a complete cell, the block reads that cell one octet per clock. Otherwise it makes up an idle cell for the slot. Each user cell arrives with a known test value in its fifth octet. The block compares that octet with the expected pattern and then overwrites it with the header error check computed over the first four octets.

A mismatch sets a sticky error flag. The flag is cleared by a control/status read strobe, and an enable masks it onto an interrupt line. Idle cells get a computed check octet or a fixed programmable byte in octet five. An external one-bit serial input can supply the 4-bit flow-control nibble of user cells in place of the value the cell source wrote.

Top module: `tx_octet5_proc`

## Requirements
- R1: Output octets come one per clock in slots of 53, with `tx_sof` high on the first octet of each slot. Each output octet appears one clock after the octet index that produced it. Every octet of a user cell other than octet 5 (and octet 1 bits 7:4 when R8 applies) passes through unchanged.
- R2: `fifo_rd` is high for all 53 octets of a slot exactly when `fifo_cell_avail` is high during the first octet of that slot. `fifo_data` is ignored in slots where `fifo_rd` is low.
- R3: The expected fifth octet of a user cell is 55h when `pat_const`=1. When `pat_const`=0, it is 55h for the first user cell after reset and then alternates AAh, 55h, and so on. The sequence advances once per user cell in either mode, whether or not that cell matched.
- R4: A fifth-octet mismatch sets `err_status` on the clock that ends octet 5, and the flag holds until a clock with `csr_rd`=1 clears it. If a read and a mismatch fall on the same clock, the flag stays set.
- R5: `irq` is high exactly when `err_status`=1 and `irq_en`=1.
- R6: Octet 5 of a user cell is replaced by CRC-8 (polynomial x^8+x^2+x+1, initial value 0) over output octets 1–4, XORed with 55h.
- R7: Idle cells carry octets 00h, 00h, 00h, 01h, then octet 5, then 48 octets of 6Ah. Octet 5 is the R6 value (52h) when `idle_hec_en`=1 and `idle_byte5` when it is 0. Idle cells never affect `err_status`.
- R8: `gfc_ser_in` is sampled on octets 1–4 of every slot, most significant bit first. When `gfc_en`=1, the collected nibble replaces bits 7:4 of octet 1 of a user cell in the next slot, and the HEC is computed over the result. When `gfc_en`=0, octet 1 is left as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_cell_avail | input | 1 | FIFO holds at least one complete cell |
| fifo_data | input | 8 | FIFO octet, valid in the cycle `fifo_rd` is high |
| fifo_rd | output | 1 | Read strobe, one octet per cycle |
| gfc_ser_in | input | 1 | Serial flow-control nibble, MSB first |
| gfc_en | input | 1 | Use serial nibble in octet 1 bits 7:4 |
| pat_const | input | 1 | 1: constant 55h test pattern, 0: alternating |
| irq_en | input | 1 | Interrupt enable for the integrity error |
| idle_hec_en | input | 1 | 1: computed check octet in idle cells |
| idle_byte5 | input | 8 | Idle-cell octet 5 when `idle_hec_en`=0 |
| csr_rd | input | 1 | Status read strobe, clears `err_status` |
| tx_data | output | 8 | Outgoing octet |
| tx_sof | output | 1 | First octet of a slot |
| err_status | output | 1 | Sticky integrity-error flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check four properties on every cycle. The read strobe stays fixed across a slot. Slot starts are never back to back. The error flag drops only after a read strobe and rises only after a user cell. The interrupt stays quiet while masked. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock: the check octet values and the alternation sequence across cells and modes, idle cell contents in both octet-five modes, placement of the serial nibble, and a read that coincides with a mismatch.

// File: rtl/tx_octet5_proc.sv
module tx_octet5_proc #(
  parameter int          CELL_LEN  = 53,
  parameter int          HDR_LEN   = 4,
  parameter logic [7:0]  PAT_A     = 8'h55,
  parameter logic [7:0]  PAT_B     = 8'hAA,
  parameter logic [7:0]  HEC_COSET = 8'h55,
  parameter logic [7:0]  IDLE_FILL = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_cell_avail,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  input  logic       gfc_ser_in,
  input  logic       gfc_en,
  input  logic       pat_const,
  input  logic       irq_en,
  input  logic       idle_hec_en,
  input  logic [7:0] idle_byte5,
  input  logic       csr_rd,
  output logic [7:0] tx_data,
  output logic       tx_sof,
  output logic       err_status,
  output logic       irq
);
  localparam int IW = $clog2(CELL_LEN);

  logic [IW-1:0] idx;
  logic          user_q, alt;
  logic [7:0]    crc, idle_b, src, out_b;
  logic [3:0]    gfc_sh, gfc_hold;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  wire first   = (idx == '0);
  wire user    = first ? fifo_cell_avail : user_q;
  wire oct5    = (idx == IW'(HDR_LEN));
  wire [7:0] exp_pat = (pat_const || !alt) ? PAT_A : PAT_B;
  wire mism    = user && oct5 && (fifo_data != exp_pat);

  assign fifo_rd = user;
  assign irq     = err_status & irq_en;

  always_comb begin
    if (idx < IW'(HDR_LEN - 1))       idle_b = 8'h00;
    else if (idx == IW'(HDR_LEN - 1)) idle_b = 8'h01;
    else                              idle_b = IDLE_FILL;
  end

  assign src = user ? fifo_data : idle_b;

  always_comb begin
    out_b = src;
    if (first && user && gfc_en) out_b[7:4] = gfc_hold;
    if (oct5) out_b = (user || idle_hec_en) ? (crc ^ HEC_COSET) : idle_byte5;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      user_q     <= 1'b0;
      alt        <= 1'b0;
      crc        <= '0;
      gfc_sh     <= '0;
      gfc_hold   <= '0;
      err_status <= 1'b0;
      tx_data    <= '0;
      tx_sof     <= 1'b0;
    end else begin
      idx        <= (idx == IW'(CELL_LEN - 1)) ? '0 : idx + 1'b1;
      if (first) user_q <= fifo_cell_avail;
      if (first)                       crc <= crc8_step(8'h00, out_b);
      else if (idx < IW'(HDR_LEN))     crc <= crc8_step(crc, out_b);
      if (user && oct5) alt <= ~alt;
      if (idx < IW'(4)) gfc_sh <= {gfc_sh[2:0], gfc_ser_in};
      if (idx == IW'(CELL_LEN - 1)) gfc_hold <= gfc_sh;
      err_status <= mism | (err_status & ~csr_rd);
      tx_data    <= out_b;
      tx_sof     <= first;
    end
  end
endmodule

// File: rtl/tx_octet5_chk.sv
module tx_octet5_chk #(parameter int IW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] idx,
  input logic          fifo_rd,
  input logic          tx_sof,
  input logic          csr_rd,
  input logic          err_status,
  input logic          irq,
  input logic          irq_en
);
  // R1
  sof_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> !tx_sof);

  // R2
  rd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0) |-> (fifo_rd == $past(fifo_rd)));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status && !csr_rd) |=> err_status);

  // R4
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_status) |-> $past(fifo_rd));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind tx_octet5_proc tx_octet5_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .fifo_rd(fifo_rd), .tx_sof(tx_sof),
  .csr_rd(csr_rd), .err_status(err_status), .irq(irq), .irq_en(irq_en)
);

// File: tb/sim_tx_octet5_proc.sv
module sim_tx_octet5_proc;
  typedef logic [7:0] cell_t [53];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_cell_avail = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_rd;
  logic gfc_ser_in = 1'b0;
  logic gfc_en = 1'b0, pat_const = 1'b0, irq_en = 1'b0, idle_hec_en = 1'b1;
  logic [7:0] idle_byte5 = 8'h3C;
  logic csr_rd = 1'b0;
  logic [7:0] tx_data;
  logic tx_sof, err_status, irq;

  always #10 clk = ~clk;

  tx_octet5_proc u0 (
    .clk(clk), .rst_n(rst_n), .fifo_cell_avail(fifo_cell_avail), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .gfc_ser_in(gfc_ser_in), .gfc_en(gfc_en), .pat_const(pat_const),
    .irq_en(irq_en), .idle_hec_en(idle_hec_en), .idle_byte5(idle_byte5), .csr_rd(csr_rd),
    .tx_data(tx_data), .tx_sof(tx_sof), .err_status(err_status), .irq(irq)
  );

  int compared = 0, mismatched = 0;
  bit running = 0, finished = 0;
  cell_t q[$];
  cell_t cur;
  int ncell = 0;
  logic [3:0] gfc_next = 4'h0;

  int midx = 0;
  bit muser = 0, malt = 0, merr = 0, have_exp = 0;
  logic [3:0] mgsh = 0, mghold = 0;
  logic [31:0] mhdr;
  logic [7:0] exp_data;
  bit exp_sof;
  string exp_tag;

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[7] ^ h[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r ^ 8'h55;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h (t=%0t)", tag, act, expv, $time);
    end
  endtask

  task automatic push_cell(input logic [7:0] b5);
    cell_t c;
    for (int i = 0; i < 53; i++) c[i] = 8'((ncell * 37 + i * 13 + 5) & 8'hFF);
    c[4] = b5;
    q.push_back(c);
    ncell++;
  endtask

  function automatic logic [7:0] good_b5();
    return (pat_const || (ncell % 2 == 0)) ? 8'h55 : 8'hAA;
  endfunction

  // Behavioural reference model, stepped at each falling edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [7:0] b;
      bit mism;
      if (have_exp) begin
        check(exp_tag, tx_data, exp_data);
        check("R1 sof", {7'd0, tx_sof}, {7'd0, exp_sof});
        check("R3 R4 err_status", {7'd0, err_status}, {7'd0, merr});
        check("R5 irq", {7'd0, irq}, {7'd0, merr & irq_en});
      end
      fifo_cell_avail = (q.size() > 0);
      if (midx == 0) begin
        muser = (q.size() > 0);
        if (muser) cur = q.pop_front();
      end
      fifo_data  = muser ? cur[midx] : 8'hC3;
      gfc_ser_in = (midx < 4) ? gfc_next[3 - midx] : 1'b0;
      if (muser) b = cur[midx];
      else b = (midx < 3) ? 8'h00 : (midx == 3) ? 8'h01 : 8'h6A;
      exp_tag = muser ? "R1 user octet" : "R7 idle octet";
      if (midx == 0 && muser && gfc_en) begin
        b = {mghold, b[3:0]};
        exp_tag = "R8 octet1";
      end
      if (midx < 4) mhdr[31 - 8*midx -: 8] = b;
      mism = 0;
      if (midx == 4) begin
        if (muser) begin
          mism = (cur[4] != ((pat_const || !malt) ? 8'h55 : 8'hAA));
          malt = !malt;
          b = hec_of(mhdr);
          exp_tag = "R6 user hec";
        end else begin
          b = idle_hec_en ? hec_of(mhdr) : idle_byte5;
          exp_tag = "R7 idle octet5";
        end
      end
      merr = mism | (merr & !csr_rd);
      if (midx < 4) mgsh = {mgsh[2:0], gfc_ser_in};
      if (midx == 52) mghold = mgsh;
      exp_data = b;
      exp_sof  = (midx == 0);
      have_exp = 1;
      #1;
      check("R2 fifo_rd", {7'd0, fifo_rd}, {7'd0, muser});
      midx = (midx + 1) % 53;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_slots(input int n);
    repeat (n * 53) step();
  endtask

  initial begin
    repeat (3) step();
    check("R1 reset tx_data", tx_data, 8'h00);
    check("R1 reset tx_sof", {7'd0, tx_sof}, 8'h00);
    check("R4 reset err_status", {7'd0, err_status}, 8'h00);
    check("R5 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    running = 1;
    wait_slots(2);
    push_cell(good_b5()); push_cell(good_b5()); push_cell(good_b5());
    wait_slots(4);
    push_cell(good_b5() ^ 8'hFF);
    wait_slots(2);
    irq_en = 1'b1;
    wait_slots(1);
    csr_rd = 1'b1; step(); csr_rd = 1'b0;
    wait_slots(1);
    pat_const = 1'b1;
    push_cell(good_b5()); push_cell(good_b5());
    wait_slots(3);
    pat_const = 1'b0;
    push_cell(good_b5());
    wait_slots(2);
    idle_hec_en = 1'b0;
    wait_slots(2);
    gfc_en = 1'b1; gfc_next = 4'hA;
    wait_slots(1);
    push_cell(good_b5()); push_cell(good_b5());
    wait_slots(1);
    gfc_next = 4'h5;
    wait_slots(2);
    csr_rd = 1'b1;
    push_cell(8'h12);
    wait_slots(2);
    csr_rd = 1'b0;
    irq_en = 1'b0;
    push_cell(8'h00);
    wait_slots(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule